// File: doc/BRIEF.md
# Channel I/O Sequence Controller

This block is the channel-side sequencer that carries one I/O instruction across a parallel device interface. A request names a device, an eight-bit command, a direction and, for writes, a data word. The controller places the select strobe, device address and command on the address bus, drives write data when needed, and waits out a minimum deskew interval before it raises address gate. It then waits for the device to answer with address gate return. A maximum-delay watchdog bounds this wait.

When the device answers, the controller captures the condition code and, on reads, the inbound data. It pulses data strobe, lowers gate and strobe together, waits for the return line to fall and then releases the buses. If the device stays silent, the controller lowers address gate, releases the buses one cycle later, never pulses data strobe, and reports condition code 0, which means the device is not attached. All intervals are written in nanoseconds and turned into clock cycles by rounding up against a clock-period parameter. The device-side inputs are assumed to be synchronous to the clock.

Top module: `chan_seq`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, agate_o, dstrobe_o, dbus_oe_o, abus_o, dbus_o, done_cc_o and done_rdata_o are all zero, and the sequencer is idle once reset is released.
- R2: A request is taken only when the block is idle. busy_o is high from the cycle after acceptance until the cycle in which done_o pulses. A request raised while busy_o is high changes neither the buses nor the sequence, and it does not start a new sequence afterwards.
- R3: From the cycle after acceptance until release, abus_o[16] is 1, abus_o[15:8] carries the device address and abus_o[7:0] carries the command. dbus_oe_o is 1 and dbus_o carries the write word only on write requests. Otherwise both are 0.
- R4: agate_o rises exactly ceil(DESKEW_NS / CLK_PERIOD_NS) cycles after the buses become valid.
- R5: When agate_ret_i is seen high while the gate is up, cc_in_i and dbus_i are captured, and dstrobe_o is then high for STROBE_CYC cycles with agate_o high. agate_o and dstrobe_o fall in the same cycle.
- R6: After the gate falls, the buses stay driven until agate_ret_i is low, and they are released at least one cycle after agate_o. done_o pulses for one cycle at release, with done_cc_o and done_rdata_o valid. These outputs hold until the next acceptance.
- R7: If agate_ret_i is not seen within ceil(TIMEOUT_NS / CLK_PERIOD_NS) cycles of gate high, agate_o falls, dstrobe_o never rises, the buses are released one cycle after the gate, and done_o pulses with done_cc_o = 0 and done_rdata_o = 0.
- R8: On a write sequence, done_rdata_o reports 0 whatever the device places on dbus_i.
- R9: A return seen in the last cycle of the timeout window still counts as a successful response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_dev_i | input | 8 | Device address |
| req_cmd_i | input | 8 | Command byte |
| req_write_i | input | 1 | 1 = write sequence, 0 = read |
| req_wdata_i | input | 16 | Write data word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| done_cc_o | output | 3 | Reported condition code (0 = not attached) |
| done_rdata_o | output | 16 | Captured read data |
| abus_o | output | 17 | Address bus: [16] select, [15:8] device, [7:0] command |
| dbus_o | output | 16 | Outbound data bus |
| dbus_oe_o | output | 1 | Outbound data bus enable |
| agate_o | output | 1 | Address gate |
| agate_ret_i | input | 1 | Address gate return from device |
| cc_in_i | input | 3 | Condition code from device |
| dbus_i | input | 16 | Inbound data bus |
| dstrobe_o | output | 1 | Data strobe |

## Verification
The bench builds the block with an 8 ns clock period, a 204 ns deskew, a 3000 ns timeout and a three-cycle strobe. The 204 ns deskew does not divide evenly by the period, so the round-up to 26 cycles can be seen at the ports. The timeout works out to 375 cycles, which is short enough to run both a full silent-device window and a device that answers in the very last cycle of that window. The short strobe keeps each sequence brief, so read, write, late-response and request-while-busy patterns all fit into one run.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESKEW,
    ST_GATE,
    ST_STROBE,
    ST_RETLOW,
    ST_DROP
  } seq_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/chan_seq_timer.sv
module chan_seq_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/chan_seq_bus.sv
module chan_seq_bus #(
  parameter int DEV_W  = 8,
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  parameter int CC_W   = 3,
  localparam int ABUS_W = DEV_W + CMD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              drive_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [CC_W-1:0]   cc_in_i,
  input  logic [DATA_W-1:0] dbus_i,
  output logic [ABUS_W-1:0] abus_o,
  output logic [DATA_W-1:0] dbus_o,
  output logic              dbus_oe_o,
  output logic [CC_W-1:0]   cc_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DEV_W-1:0]  dev_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CC_W-1:0]   cc_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q   <= '0;
      cmd_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept_i) begin
      dev_q   <= req_dev_i;
      cmd_q   <= req_cmd_i;
      wr_q    <= req_write_i;
      wdata_q <= req_wdata_i;
    end
  end

  // result clears on accept so a timeout reports zeros
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q    <= '0;
      rdata_q <= '0;
    end else if (accept_i) begin
      cc_q    <= '0;
      rdata_q <= '0;
    end else if (capture_i) begin
      cc_q    <= cc_in_i;
      rdata_q <= wr_q ? '0 : dbus_i;
    end
  end

  assign abus_o    = drive_i ? {1'b1, dev_q, cmd_q} : '0;
  assign dbus_oe_o = drive_i & wr_q;
  assign dbus_o    = (drive_i && wr_q) ? wdata_q : '0;
  assign cc_o      = cc_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/chan_seq_ctrl.sv
module chan_seq_ctrl
  import chan_seq_pkg::*;
#(
  parameter int DESKEW_CYC  = 20,
  parameter int TIMEOUT_CYC = 300,
  parameter int STROBE_CYC  = 4,
  parameter int CNT_W       = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             ret_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             busy_o,
  output logic             agate_o,
  output logic             dstrobe_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] DSK_LD = CNT_W'(DESKEW_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LD = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] STB_LD = CNT_W'(STROBE_CYC - 1);

  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d    = ST_DESKEW;
        accept_o   = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = DSK_LD;
      end
      ST_DESKEW: if (tmr_zero_i) begin
        state_d    = ST_GATE;
        tmr_load_o = 1'b1;
        tmr_val_o  = TMO_LD;
      end
      ST_GATE: begin
        // a return in the final window cycle wins over the timeout
        if (ret_i) begin
          state_d    = ST_STROBE;
          capture_o  = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o  = STB_LD;
        end else if (tmr_zero_i) begin
          state_d = ST_DROP;
        end
      end
      ST_STROBE: if (tmr_zero_i) state_d = ST_RETLOW;
      ST_RETLOW: if (!ret_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_DROP: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign agate_o   = (state_q == ST_GATE) || (state_q == ST_STROBE);
  assign dstrobe_o = (state_q == ST_STROBE);
  assign done_o    = done_q;
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import chan_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int DESKEW_NS     = 200,
  parameter int TIMEOUT_NS    = 3000,
  parameter int STROBE_CYC    = 4,
  parameter int DEV_W         = 8,
  parameter int CMD_W         = 8,
  parameter int DATA_W        = 16,
  parameter int CC_W          = 3,
  localparam int ABUS_W       = DEV_W + CMD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CC_W-1:0]   done_cc_o,
  output logic [DATA_W-1:0] done_rdata_o,
  output logic [ABUS_W-1:0] abus_o,
  output logic [DATA_W-1:0] dbus_o,
  output logic              dbus_oe_o,
  output logic              agate_o,
  input  logic              agate_ret_i,
  input  logic [CC_W-1:0]   cc_in_i,
  input  logic [DATA_W-1:0] dbus_i,
  output logic              dstrobe_o
);
  localparam int DESKEW_CYC  = ceil_div(DESKEW_NS, CLK_PERIOD_NS);
  localparam int TIMEOUT_CYC = ceil_div(TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int MAX_A       = (DESKEW_CYC > TIMEOUT_CYC) ? DESKEW_CYC : TIMEOUT_CYC;
  localparam int MAX_CYC     = (MAX_A > STROBE_CYC) ? MAX_A : STROBE_CYC;
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  chan_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  chan_seq_ctrl #(
    .DESKEW_CYC  (DESKEW_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .STROBE_CYC  (STROBE_CYC),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ret_i       (agate_ret_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .accept_o    (accept),
    .capture_o   (capture),
    .busy_o      (busy_o),
    .agate_o     (agate_o),
    .dstrobe_o   (dstrobe_o),
    .done_o      (done_o)
  );

  chan_seq_bus #(
    .DEV_W  (DEV_W),
    .CMD_W  (CMD_W),
    .DATA_W (DATA_W),
    .CC_W   (CC_W)
  ) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .drive_i     (busy_o),
    .req_dev_i   (req_dev_i),
    .req_cmd_i   (req_cmd_i),
    .req_write_i (req_write_i),
    .req_wdata_i (req_wdata_i),
    .cc_in_i     (cc_in_i),
    .dbus_i      (dbus_i),
    .abus_o      (abus_o),
    .dbus_o      (dbus_o),
    .dbus_oe_o   (dbus_oe_o),
    .cc_o        (done_cc_o),
    .rdata_o     (done_rdata_o)
  );
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk
  import chan_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int DESKEW_NS     = 200,
  parameter int TIMEOUT_NS    = 3000,
  parameter int ABUS_W        = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ABUS_W-1:0] abus_o,
  input logic              dbus_oe_o,
  input logic              agate_o,
  input logic              dstrobe_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int DSK = ceil_div(DESKEW_NS, CLK_PERIOD_NS);
  localparam int TMO = ceil_div(TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int DW  = $clog2(DSK + 2);
  localparam int TW  = $clog2(TMO + 2);

  logic          sel;
  logic [DW-1:0] sel_cnt;
  logic [TW-1:0] gate_cnt;

  assign sel = abus_o[ABUS_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    sel_cnt <= '0;
    else if (!sel)                                  sel_cnt <= '0;
    else if (!agate_o && sel_cnt < DW'(DSK + 1))    sel_cnt <= sel_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    gate_cnt <= '0;
    else if (!agate_o || dstrobe_o)                 gate_cnt <= '0;
    else if (gate_cnt < TW'(TMO + 1))               gate_cnt <= gate_cnt + 1'b1;
  end

  a_r4_deskew_met: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(agate_o) |-> sel_cnt >= DW'(DSK));
  a_r7_gate_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_cnt <= TW'(TMO));
  a_r5_strobe_in_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstrobe_o |-> agate_o);
  a_r5_drop_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dstrobe_o) |-> $fell(agate_o));
  a_r6_gate_before_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel) |-> $past(!agate_o));
  a_r3_oe_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbus_oe_o |-> sel);
  a_r2_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(abus_o));
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind chan_seq chan_seq_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .DESKEW_NS     (DESKEW_NS),
  .TIMEOUT_NS    (TIMEOUT_NS),
  .ABUS_W        (ABUS_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .abus_o    (abus_o),
  .dbus_oe_o (dbus_oe_o),
  .agate_o   (agate_o),
  .dstrobe_o (dstrobe_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/chan_seq_tb_top.sv
module chan_seq_tb_top;
  localparam int STB     = 3;
  localparam int DSK_EXP = 26;   // ceil(204/8)
  localparam int TMO_EXP = 375;  // ceil(3000/8)

  typedef struct packed {
    logic        wr;
    logic [7:0]  dev;
    logic [7:0]  cmd;
    logic [15:0] wdata;
    logic        resp;
    logic [8:0]  dly;
    logic [2:0]  cc;
    logic [15:0] rdata;
    logic        poke;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 8'h12, 8'h30, 16'h0000, 1'b1, 9'd0,   3'd7, 16'hBEEF, 1'b0},
    '{1'b1, 8'hA5, 8'h41, 16'h1234, 1'b1, 9'd10,  3'd2, 16'hFFFF, 1'b1},
    '{1'b0, 8'h00, 8'hFF, 16'h0000, 1'b1, 9'd374, 3'd5, 16'h0F0F, 1'b0},
    '{1'b0, 8'h7E, 8'h02, 16'h0000, 1'b0, 9'd0,   3'd6, 16'h1111, 1'b1},
    '{1'b1, 8'hFF, 8'h00, 16'hCAFE, 1'b0, 9'd0,   3'd3, 16'h2222, 1'b0},
    '{1'b1, 8'h33, 8'h81, 16'h5A5A, 1'b1, 9'd1,   3'd1, 16'h7777, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_dev = '0;
  logic [7:0]  req_cmd = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        ret = 1'b0;
  logic [2:0]  cc_in = '0;
  logic [15:0] dbus_in = '0;
  logic        busy, done, dbus_oe, agate, dstrobe;
  logic [2:0]  done_cc;
  logic [15:0] done_rdata, dbus_out;
  logic [16:0] abus;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  chan_seq #(
    .CLK_PERIOD_NS (8),
    .DESKEW_NS     (204),
    .TIMEOUT_NS    (3000),
    .STROBE_CYC    (STB)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid),
    .req_dev_i    (req_dev),
    .req_cmd_i    (req_cmd),
    .req_write_i  (req_write),
    .req_wdata_i  (req_wdata),
    .busy_o       (busy),
    .done_o       (done),
    .done_cc_o    (done_cc),
    .done_rdata_o (done_rdata),
    .abus_o       (abus),
    .dbus_o       (dbus_out),
    .dbus_oe_o    (dbus_oe),
    .agate_o      (agate),
    .agate_ret_i  (ret),
    .cc_in_i      (cc_in),
    .dbus_i       (dbus_in),
    .dstrobe_o    (dstrobe)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic run_vec(input vec_t v);
    int d, g, s;
    logic seen_stb;
    logic [16:0] abus_exp;
    abus_exp = {1'b1, v.dev, v.cmd};
    @(negedge clk);
    req_valid = 1'b1; req_dev = v.dev; req_cmd = v.cmd;
    req_write = v.wr; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", busy, 1);
    chk("R3 address bus", abus, abus_exp);
    chk("R3 data enable", dbus_oe, v.wr);
    chk("R3 data bus", dbus_out, v.wr ? v.wdata : 16'h0);
    d = 0;
    while (!agate) begin
      if (v.poke && d == 3) begin
        req_valid = 1'b1; req_dev = ~v.dev; req_cmd = ~v.cmd; req_write = ~v.wr;
      end
      if (v.poke && d == 4) begin
        req_valid = 1'b0;
        chk("R2 request ignored while busy", abus, abus_exp);
      end
      d++;
      @(negedge clk);
    end
    chk("R4 deskew cycles", d, DSK_EXP);
    if (v.resp) begin
      for (int k = 0; k < int'(v.dly); k++) @(negedge clk);
      chk("R9/R5 gate still up before return", agate, 1);
      ret = 1'b1; cc_in = v.cc; dbus_in = v.rdata;
      @(negedge clk);
      s = 0;
      while (dstrobe) begin
        if (!agate) chk("R5 gate during strobe", agate, 1);
        s++;
        @(negedge clk);
      end
      chk("R5 strobe width", s, STB);
      chk("R5 gate falls with strobe", agate, 0);
      chk("R6 bus held after gate", abus, abus_exp);
      ret = 1'b0; cc_in = '0; dbus_in = '0;
      @(negedge clk);
      chk("R6 done pulse", done, 1);
      chk("R6 bus released", abus, 0);
      chk("R6 busy low", busy, 0);
      chk("R6 cc reported", done_cc, v.cc);
      chk("R8 rdata reported", done_rdata, v.wr ? 16'h0 : v.rdata);
    end else begin
      g = 0; seen_stb = 1'b0;
      while (agate) begin
        if (dstrobe) seen_stb = 1'b1;
        g++;
        @(negedge clk);
      end
      chk("R7 timeout window", g, TMO_EXP);
      chk("R7 no strobe", seen_stb, 0);
      chk("R7 bus held one cycle", abus, abus_exp);
      @(negedge clk);
      chk("R7 done pulse", done, 1);
      chk("R7 cc not attached", done_cc, 0);
      chk("R7 rdata zero", done_rdata, 0);
      chk("R7 bus released", abus, 0);
    end
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    chk("R2 stays idle", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset gate", agate, 0);
    chk("R1 reset bus", abus, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {busy, done, agate, dstrobe, dbus_oe}, 0);
    chk("R1 results zero", {done_cc, done_rdata, dbus_out}, 0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R1: reset in the middle of a gated sequence
    @(negedge clk);
    req_valid = 1'b1; req_dev = 8'h44; req_cmd = 8'h55; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (DSK_EXP + 5) @(negedge clk);
    chk("R1 gate up before reset", agate, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset clears", {busy, agate, dstrobe, dbus_oe}, 0);
    chk("R1 async reset bus", abus, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after mid reset", busy, 0);

    run_vec(VEC[0]);
    finish_run();
  end
endmodule